// File: doc/BRIEF.md
# Buzzer Tone Generator with Duty Envelope

This block drives a piezo buzzer from a low-frequency reference. Every cycle in which `ref_tick` is high counts as one period of a 32.768 kHz reference. From that time base the block makes a square wave with a selectable period and high time. It presents the wave on `bz_out` and its complement on `bz_out_n`. A smaller high time gives a quieter tone. When nothing is sounding, both pins rest low.

Two sources can make the buzzer sound:

- **Continuous tone.** The tone plays for as long as `tone_en` is held high.
- **Single burst.** `shot_go` requests a burst of fixed length. The burst starts on the next 256 Hz boundary of the reference. It is accepted only while the continuous tone is off, and `shot_stop` can end it early.

An optional envelope lowers the loudness in steps. It starts at the loudest level, moves one level per step interval and stays at the quietest level. While the envelope is on, it replaces the static loudness setting.

Control pins are plain levels and single-cycle pulses. The block has no data stream, so it has no valid/ready handshake and no back-pressure.

Top module: `buzzer_gen`

## Requirements
- R1: After reset, and whenever neither the continuous tone nor a burst is sounding, `bz_out` and `bz_out_n` are both 0 and `shot_busy` is 0.
- R2: While sounding, `bz_out_n` is the exact inverse of `bz_out`.
- R3: The tone period in reference ticks is selected by `freq_sel`: 0→8, 1→10, 2→12, 3→14, 4→16, 5→20, 6→24, 7→28.
- R4: The high time per period is max(1, floor(N·(8−L)/16)) ticks, where N is the period and L is the level index (0 to 7). L=0 is the loudest level, at half the period, and L=7 is the quietest. Without the envelope, L = `duty_sel`.
- R5: Counting advances only in cycles where `ref_tick` is 1. With a tick on every other cycle, every duration in cycles doubles.
- R6: With `env_on`=1, L starts at 0 when sounding begins, rises by one each step interval and stays at 7. `duty_sel` has no effect while the envelope is on.
- R7: The envelope step interval is 4096 ticks when `env_slow`=1 and 2048 ticks when `env_slow`=0.
- R8: A one-cycle pulse on `env_restart` returns L to 0 and restarts the step interval.
- R9: When `tone_en`=0, `shot_go` raises `shot_busy` on the next cycle. The burst then starts at the next 256 Hz point, which comes every 128 ticks counted from reset. The outputs are active for exactly 1024 ticks when `shot_long`=0, or 4096 ticks when `shot_long`=1. `shot_busy` then returns to 0.
- R10: `shot_go` while `tone_en`=1 is ignored: `shot_busy` stays 0 and no burst follows later.
- R11: `shot_stop` clears `shot_busy` on the next cycle, and both outputs are 0 one cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One pulse per 32.768 kHz reference period |
| tone_en | input | 1 | Continuous tone enable |
| freq_sel | input | 3 | Tone period select |
| duty_sel | input | 3 | Static loudness level, 0 = loudest |
| env_on | input | 1 | Envelope enable |
| env_slow | input | 1 | Envelope step: 1 = 4096 ticks, 0 = 2048 ticks |
| env_restart | input | 1 | Pulse: return envelope to the loudest level |
| shot_go | input | 1 | Pulse: request a single burst |
| shot_stop | input | 1 | Pulse: end a pending or running burst |
| shot_long | input | 1 | Burst length: 1 = 4096 ticks, 0 = 1024 ticks |
| shot_busy | output | 1 | High from an accepted request to the end of the burst |
| bz_out | output | 1 | Buzzer square wave |
| bz_out_n | output | 1 | Complement of the wave, low when idle |

## Verification
Four properties are checked on every cycle:

- both pins are low after a cycle with nothing sounding;
- a request made while the continuous tone is on never raises the busy flag;
- a stop always clears the busy flag;
- a burst can begin only on a 256 Hz boundary.

The scenarios cover the rest. They measure the period and high time for each frequency and for several loudness levels. They follow the envelope's level over tens of thousands of ticks at both step rates, including saturation and restart. They also check burst lengths, early stop, and stretching when ticks are sparse.

// File: rtl/buzzer_gen_pkg.sv
package buzzer_gen_pkg;
  localparam int unsigned PH_W  = 5;
  localparam int unsigned LVL_W = 3;

  typedef enum logic [1:0] {SHOT_IDLE, SHOT_ARM, SHOT_RUN} shot_state_t;

  // Period in reference ticks for each frequency code.
  function automatic logic [PH_W-1:0] tone_divisor(input logic [2:0] sel);
    logic [PH_W-1:0] d;
    if (!sel[2]) d = PH_W'(8) + PH_W'({sel[1:0], 1'b0});
    else         d = PH_W'(16) + PH_W'({sel[1:0], 2'b00});
    return d;
  endfunction

  // High ticks per period for a loudness level, never below one.
  function automatic logic [PH_W-1:0] high_ticks(input logic [PH_W-1:0] div,
                                                 input logic [LVL_W-1:0] lvl);
    logic [PH_W+3:0] prod;
    logic [PH_W-1:0] h;
    prod = (PH_W+4)'(div) * (PH_W+4)'(4'd8 - {1'b0, lvl});
    h = prod[PH_W+3:4];
    if (h == '0) h = PH_W'(1);
    return h;
  endfunction
endpackage

// File: rtl/buzzer_gen_tone.sv
module buzzer_gen_tone
  import buzzer_gen_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             sounding,
  input  logic [2:0]       freq_sel,
  input  logic [LVL_W-1:0] level,
  output logic             wave,
  output logic             wave_n
);
  logic [PH_W-1:0] phase, div, hi;
  logic wave_q, snd_q;

  always_comb begin
    div = tone_divisor(freq_sel);
    hi  = high_ticks(div, level);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= '0;
      wave_q <= 1'b0;
      snd_q  <= 1'b0;
    end else begin
      if (!sounding)    phase <= '0;
      else if (tick)    phase <= (phase >= div - PH_W'(1)) ? '0 : phase + PH_W'(1);
      wave_q <= sounding && (phase < hi);
      snd_q  <= sounding;
    end
  end

  assign wave   = wave_q;
  assign wave_n = snd_q & ~wave_q;
endmodule

// File: rtl/buzzer_gen_env.sv
module buzzer_gen_env
  import buzzer_gen_pkg::*;
#(
  parameter int unsigned FAST_TICKS = 2048,
  parameter int unsigned SLOW_TICKS = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             active,
  input  logic             restart,
  input  logic             slow,
  output logic [LVL_W-1:0] level
);
  localparam int unsigned CW = $clog2(SLOW_TICKS);
  localparam logic [LVL_W-1:0] TOP = '1;

  logic [CW-1:0] cnt;
  logic [LVL_W-1:0] lvl_q;
  logic step_end;

  assign step_end = cnt == (slow ? CW'(SLOW_TICKS - 1) : CW'(FAST_TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      lvl_q <= '0;
    end else if (!active || restart) begin
      cnt   <= '0;
      lvl_q <= '0;
    end else if (tick) begin
      if (step_end) begin
        cnt <= '0;
        if (lvl_q != TOP) lvl_q <= lvl_q + LVL_W'(1);
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  assign level = lvl_q;
endmodule

// File: rtl/buzzer_gen_shot.sv
module buzzer_gen_shot
  import buzzer_gen_pkg::*;
#(
  parameter int unsigned SYNC_TICKS  = 128,
  parameter int unsigned SHORT_TICKS = 1024,
  parameter int unsigned LONG_TICKS  = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic tone_en,
  input  logic go,
  input  logic stop,
  input  logic long_sel,
  output logic busy,
  output logic run,
  output logic sync_hit
);
  localparam int unsigned SW = $clog2(SYNC_TICKS);
  localparam int unsigned LW = $clog2(LONG_TICKS);

  shot_state_t state;
  logic [SW-1:0] sync_cnt;
  logic [LW-1:0] len_cnt;
  logic long_q;
  logic len_end;

  assign sync_hit = tick && (sync_cnt == SW'(SYNC_TICKS - 1));
  assign len_end  = len_cnt == (long_q ? LW'(LONG_TICKS - 1) : LW'(SHORT_TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             sync_cnt <= '0;
    else if (sync_hit)      sync_cnt <= '0;
    else if (tick)          sync_cnt <= sync_cnt + SW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SHOT_IDLE;
      len_cnt <= '0;
      long_q  <= 1'b0;
    end else if (stop) begin
      state   <= SHOT_IDLE;
    end else begin
      unique case (state)
        SHOT_IDLE: if (go && !tone_en) begin
          state  <= SHOT_ARM;
          long_q <= long_sel;
        end
        SHOT_ARM: if (sync_hit) begin
          state   <= SHOT_RUN;
          len_cnt <= '0;
        end
        SHOT_RUN: if (tick) begin
          if (len_end) state <= SHOT_IDLE;
          else         len_cnt <= len_cnt + LW'(1);
        end
        default: state <= SHOT_IDLE;
      endcase
    end
  end

  assign busy = state != SHOT_IDLE;
  assign run  = state == SHOT_RUN;
endmodule

// File: rtl/buzzer_gen.sv
module buzzer_gen
  import buzzer_gen_pkg::*;
#(
  parameter int unsigned SYNC_TICKS     = 128,
  parameter int unsigned ENV_FAST_TICKS = 2048,
  parameter int unsigned ENV_SLOW_TICKS = 4096,
  parameter int unsigned SHOT_SHORT     = 1024,
  parameter int unsigned SHOT_LONG      = 4096
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_tick,
  input  logic       tone_en,
  input  logic [2:0] freq_sel,
  input  logic [2:0] duty_sel,
  input  logic       env_on,
  input  logic       env_slow,
  input  logic       env_restart,
  input  logic       shot_go,
  input  logic       shot_stop,
  input  logic       shot_long,
  output logic       shot_busy,
  output logic       bz_out,
  output logic       bz_out_n
);
  logic shot_run, sync_hit, sounding;
  logic [LVL_W-1:0] env_level, level;

  buzzer_gen_shot #(
    .SYNC_TICKS(SYNC_TICKS), .SHORT_TICKS(SHOT_SHORT), .LONG_TICKS(SHOT_LONG)
  ) shot_i (
    .clk(clk), .rst_n(rst_n), .tick(ref_tick), .tone_en(tone_en),
    .go(shot_go), .stop(shot_stop), .long_sel(shot_long),
    .busy(shot_busy), .run(shot_run), .sync_hit(sync_hit)
  );

  assign sounding = tone_en | shot_run;

  buzzer_gen_env #(
    .FAST_TICKS(ENV_FAST_TICKS), .SLOW_TICKS(ENV_SLOW_TICKS)
  ) env_i (
    .clk(clk), .rst_n(rst_n), .tick(ref_tick), .active(sounding && env_on),
    .restart(env_restart), .slow(env_slow), .level(env_level)
  );

  assign level = env_on ? env_level : LVL_W'(duty_sel);

  buzzer_gen_tone tone_i (
    .clk(clk), .rst_n(rst_n), .tick(ref_tick), .sounding(sounding),
    .freq_sel(freq_sel), .level(level), .wave(bz_out), .wave_n(bz_out_n)
  );
endmodule

// File: rtl/buzzer_gen_chk.sv
module buzzer_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic tone_en,
  input logic shot_go,
  input logic shot_stop,
  input logic shot_busy,
  input logic bz_out,
  input logic bz_out_n,
  input logic sounding,
  input logic shot_run,
  input logic sync_hit
);
  assert_idle_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sounding) |-> (!bz_out && !bz_out_n));

  assert_go_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tone_en && shot_go && !shot_busy) |=> !shot_busy);

  assert_sync_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shot_run) |-> $past(sync_hit));

  assert_stop_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    shot_stop |=> !shot_busy);
endmodule

bind buzzer_gen buzzer_gen_chk chk_i (
  .clk(clk), .rst_n(rst_n), .tone_en(tone_en), .shot_go(shot_go),
  .shot_stop(shot_stop), .shot_busy(shot_busy), .bz_out(bz_out),
  .bz_out_n(bz_out_n), .sounding(sounding), .shot_run(shot_run),
  .sync_hit(sync_hit)
);

// File: tb/buzzer_gen_tb.sv
module buzzer_gen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_tick = 1'b1;
  logic tone_en = 1'b0, env_on = 1'b0, env_slow = 1'b0, env_restart = 1'b0;
  logic shot_go = 1'b0, shot_stop = 1'b0, shot_long = 1'b0;
  logic [2:0] freq_sel = 3'd0, duty_sel = 3'd0;
  logic shot_busy, bz_out, bz_out_n;
  logic half_rate = 1'b0;

  int n_cmp = 0, n_bad = 0;
  longint cyc = 0;

  typedef struct { int period; int high; string tag; } wave_t;
  wave_t sb[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) ref_tick <= half_rate ? ~ref_tick : 1'b1;

  buzzer_gen dut_i (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .tone_en(tone_en),
    .freq_sel(freq_sel), .duty_sel(duty_sel), .env_on(env_on),
    .env_slow(env_slow), .env_restart(env_restart), .shot_go(shot_go),
    .shot_stop(shot_stop), .shot_long(shot_long), .shot_busy(shot_busy),
    .bz_out(bz_out), .bz_out_n(bz_out_n)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_div(input int sel);
    int t[8] = '{8, 10, 12, 14, 16, 20, 24, 28};
    return t[sel];
  endfunction

  function automatic int exp_high(input int n, input int lvl);
    int h = (n * (8 - lvl)) / 16;
    return (h < 1) ? 1 : h;
  endfunction

  // Driver side of the scoreboard: queue an expectation, wait for it to be compared.
  task automatic expect_wave(input int p, input int h, input string tag);
    wave_t w;
    w.period = p; w.high = h; w.tag = tag;
    sb.push_back(w);
    wait (sb.size() == 0);
  endtask

  // Monitor: measure one complete pulse and compare with the head of the queue.
  initial begin
    forever begin
      int h, p;
      wave_t w;
      wait (sb.size() > 0);
      do @(negedge clk); while (bz_out !== 1'b0);
      do @(negedge clk); while (bz_out !== 1'b1);
      h = 0; p = 0;
      while (bz_out === 1'b1) begin
        chk(bz_out_n === 1'b0, "R2 complement", bz_out_n, 0);
        h++; p++; @(negedge clk);
      end
      while (bz_out === 1'b0) begin p++; @(negedge clk); end
      w = sb[0];
      chk(p == w.period, {w.tag, " period"}, p, w.period);
      chk(h == w.high, {w.tag, " high"}, h, w.high);
      void'(sb.pop_front());
    end
  end

  task automatic wait_until(input longint t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; @(negedge clk); s = 1'b0;
  endtask

  task automatic run_shot(input bit lng, input int exp_len, input string tag);
    int act;
    shot_long = lng;
    pulse(shot_go);
    chk(shot_busy === 1'b1, {tag, " busy on request"}, shot_busy, 1);
    act = 0;
    for (int i = 0; i < 6000; i++) begin
      if (bz_out | bz_out_n) act++;
      if (!shot_busy && !bz_out && !bz_out_n && i > 200) break;
      @(negedge clk);
    end
    chk(act == exp_len, {tag, " burst length"}, act, exp_len);
  endtask

  initial begin
    longint t0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(bz_out === 1'b0 && bz_out_n === 1'b0, "R1 idle outputs", {bz_out, bz_out_n}, 0);
    chk(shot_busy === 1'b0, "R1 idle busy", shot_busy, 0);

    // R3: every frequency code at the loudest level
    tone_en = 1'b1;
    for (int s = 0; s < 8; s++) begin
      freq_sel = 3'(s);
      expect_wave(exp_div(s), exp_high(exp_div(s), 0), $sformatf("R3 freq_sel=%0d", s));
    end
    // R4: loudness levels
    freq_sel = 3'd7; duty_sel = 3'd3;
    expect_wave(28, exp_high(28, 3), "R4 N=28 L=3");
    freq_sel = 3'd0; duty_sel = 3'd7;
    expect_wave(8, exp_high(8, 7), "R4 N=8 L=7 floor");
    freq_sel = 3'd5; duty_sel = 3'd5;
    expect_wave(20, exp_high(20, 5), "R4 N=20 L=5");
    // R5: a tick every other cycle doubles durations in cycles
    half_rate = 1'b1; freq_sel = 3'd0; duty_sel = 3'd0;
    expect_wave(16, 8, "R5 sparse ticks");
    half_rate = 1'b0;
    tone_en = 1'b0;
    repeat (4) @(negedge clk);
    chk(bz_out === 1'b0 && bz_out_n === 1'b0, "R1 outputs after tone off", {bz_out, bz_out_n}, 0);

    // R6/R7: fast envelope, static duty ignored
    freq_sel = 3'd4; duty_sel = 3'd5; env_on = 1'b1; env_slow = 1'b0;
    tone_en = 1'b1; t0 = cyc;
    wait_until(t0 + 1024);
    expect_wave(16, 8, "R6 envelope start loudest");
    wait_until(t0 + 2 * 2048 + 1024);
    expect_wave(16, exp_high(16, 2), "R7 fast step level 2");
    wait_until(t0 + 9 * 2048 + 512);
    expect_wave(16, exp_high(16, 7), "R6 envelope saturates");
    // R8: restart
    pulse(env_restart);
    expect_wave(16, 8, "R8 restart to loudest");
    tone_en = 1'b0;
    repeat (4) @(negedge clk);

    // R7: slow step
    env_slow = 1'b1; tone_en = 1'b1; t0 = cyc;
    wait_until(t0 + 2048 + 1024);
    expect_wave(16, 8, "R7 slow still level 0");
    wait_until(t0 + 4096 + 1024);
    expect_wave(16, exp_high(16, 1), "R7 slow level 1");
    tone_en = 1'b0; env_on = 1'b0; duty_sel = 3'd0;
    repeat (4) @(negedge clk);

    // R9: bursts
    run_shot(1'b0, 1024, "R9 short");
    repeat (10) @(negedge clk);
    run_shot(1'b1, 4096, "R9 long");

    // R10: request while continuous tone on
    tone_en = 1'b1;
    repeat (3) @(negedge clk);
    pulse(shot_go);
    chk(shot_busy === 1'b0, "R10 request ignored", shot_busy, 0);
    tone_en = 1'b0;
    repeat (300) @(negedge clk);
    chk(shot_busy === 1'b0 && bz_out === 1'b0 && bz_out_n === 1'b0,
        "R10 no late burst", {shot_busy, bz_out, bz_out_n}, 0);

    // R11: stop mid-burst
    shot_long = 1'b1;
    pulse(shot_go);
    repeat (300) @(negedge clk);
    chk(bz_out | bz_out_n, "R11 burst running before stop", {bz_out, bz_out_n}, 1);
    pulse(shot_stop);
    chk(shot_busy === 1'b0, "R11 busy cleared", shot_busy, 0);
    @(negedge clk);
    chk(bz_out === 1'b0 && bz_out_n === 1'b0, "R11 outputs low", {bz_out, bz_out_n}, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule